// File: doc/BRIEF.md
# External Interrupt Sense Normaliser

This block sits between a small number of external interrupt pins and a parent interrupt controller. The parent only understands two kinds of request: an active-high level or a rising edge. Each pin can be wired to a source that asserts high or low, by level or by transition. The block hides that difference. Per channel, software chooses level or edge sensing and the active sense of the pin. The block then drives one output per channel that is always either an active-high level or a single-cycle high pulse.

Every pin first passes through a two-flop synchroniser. The block then inverts the pin where the chosen sense requires it. In edge mode it turns the qualifying transition into a one-cycle pulse. Finally it gates the result with the channel enable. Configuration goes through a plain word-addressed write/read bus: a write strobe with address and data, and a read port that shows the addressed register combinationally. The bus always accepts writes, so it has no back-pressure. The pins and the request outputs are plain level signals with no handshake. The word at offset 0x0 is a global control word that is stored and read back but has no effect on the outputs.

Top module: `extirq_norm`

## Requirements
- R1: After reset every channel register reads zero, meaning disabled, edge mode and polarity bit clear. Every request output is low.
- R2: Channel n's register is at byte offset 0x4 + 4*n. Bit 16 is the enable, bit 9 selects level mode when 1 and edge mode when 0, and bit 8 is the polarity bit. These three bits read back exactly as written, and every other bit reads zero.
- R3: The global word at offset 0x0 stores and returns all 32 bits as written, and writing it does not change any request output.
- R4: In level mode with polarity set, an enabled channel's output is high while its pin is high. A pin change appears at the output on the third rising clock edge after it.
- R5: In level mode with polarity clear, an enabled channel's output is high while its pin is low, with the same three-edge latency.
- R6: In edge mode with polarity clear, each rising pin transition gives exactly one high output cycle, on the third clock edge after the transition. A falling transition gives none.
- R7: In edge mode with polarity set, each falling pin transition gives exactly one high output cycle with the same latency. A rising transition gives none.
- R8: While the enable bit is clear the channel's output is low from the first clock edge after the write, whatever the pin does. Setting the enable bit again restores the output from the next edge.
- R9: A read of any unmapped or unaligned offset returns zero, and a write to one changes no register.
- R10: A write that changes an enabled channel's configuration while it is in edge mode produces no output pulse unless a real qualifying pin transition follows.
- R11: Each channel's output depends only on its own pin and its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_pin | input | NCH (2) | Raw asynchronous interrupt pins |
| irq_req | output | NCH (2) | Normalised requests toward the parent controller |

## Verification
The assertions assume that the pins change only away from the sampling edge, so each pin value reaches the second synchroniser flop one edge after the first. They also assume that the bus address and data are stable while the write strobe is high at a clock edge. The stimulus drives every pin and bus signal shortly after the falling clock edge, and it holds each pin level for at least four clock cycles. In that time each transition passes completely through the synchroniser and edge history before the next one starts. Configuration writes are issued only while the pins are steady, so a reconfiguration can be told apart from a real pin transition.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_POS   = 16;
  localparam int unsigned LVL_POS  = 9;
  localparam int unsigned POL_POS  = 8;
  localparam int unsigned GLOB_OFS = 0;
  localparam int unsigned CH_OFS0  = 4;
  localparam int unsigned CH_STEP  = 4;

  typedef struct packed {
    logic en;
    logic lvl;
    logic pol;
  } chan_cfg_t;

  function automatic logic [DATA_W-1:0] cfg_to_word(chan_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_POS]  = c.en;
    w[LVL_POS] = c.lvl;
    w[POL_POS] = c.pol;
    return w;
  endfunction

  function automatic chan_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
    chan_cfg_t c;
    c.en  = w[EN_POS];
    c.lvl = w[LVL_POS];
    c.pol = w[POL_POS];
    return c;
  endfunction
endpackage

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output chan_cfg_t [NCH-1:0]   cfg_o
);
  logic [DATA_W-1:0]   glob_q;
  chan_cfg_t [NCH-1:0] cfg_q;
  logic                hit_glob;
  logic [NCH-1:0]      hit_ch;
  logic                hit_any;

  assign hit_glob = (bus_addr == ADDR_W'(GLOB_OFS));
  assign hit_any  = hit_glob | (|hit_ch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  glob_q <= '0;
    else if (bus_wr && hit_glob) glob_q <= bus_wdata;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit_ch[i] = (bus_addr == ADDR_W'(CH_OFS0 + CH_STEP * i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cfg_q[i] <= '0;
      else if (bus_wr && hit_ch[i]) cfg_q[i] <= word_to_cfg(bus_wdata);
    end

    // R2: a write to the channel word lands exactly in the three fields
    a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && hit_ch[i] |=> cfg_q[i].en  == $past(bus_wdata[EN_POS])
                           && cfg_q[i].lvl == $past(bus_wdata[LVL_POS])
                           && cfg_q[i].pol == $past(bus_wdata[POL_POS]));
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_glob) bus_rdata = glob_q;
    for (int i = 0; i < NCH; i++)
      if (hit_ch[i]) bus_rdata = cfg_to_word(cfg_q[i]);
  end

  assign cfg_o = cfg_q;

  // R9: writes to unmapped offsets leave all storage untouched
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !hit_any |=> $stable(cfg_q) && $stable(glob_q));

  // R9: unmapped reads return zero
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> bus_rdata == '0);
endmodule

// File: rtl/extirq_chan.sv
module extirq_chan
  import extirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg_i,
  input  logic      pin_i,
  output logic      irq_o
);
  logic [1:0] sync_q;
  logic       hist_q;
  chan_cfg_t  cfg_q;
  logic       norm;
  logic       cfg_chg;
  logic       nxt;
  logic       past_ok;

  // active sense folded into one inversion: level needs it when pol=0,
  // edge needs it when pol=1
  assign norm    = sync_q[1] ^ (cfg_i.pol ^ cfg_i.lvl);
  assign cfg_chg = (cfg_i != cfg_q);

  always_comb begin
    if (!cfg_i.en)     nxt = 1'b0;
    else if (cfg_i.lvl) nxt = norm;
    else               nxt = norm & ~hist_q & ~cfg_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      hist_q  <= 1'b0;
      cfg_q   <= '0;
      irq_o   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], pin_i};
      hist_q  <= norm;
      cfg_q   <= cfg_i;
      irq_o   <= nxt;
      past_ok <= 1'b1;
    end
  end

  // R1: reset holds the request low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !irq_o);

  // R8: a disabled channel never requests
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(cfg_i.en) |-> !irq_o);

  // R4: level, active high follows the synchronised pin
  a_r4_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cfg_i.en && cfg_i.lvl && cfg_i.pol) |-> irq_o == $past(sync_q[1]));

  // R5: level, active low follows the inverted synchronised pin
  a_r5_level_low: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cfg_i.en && cfg_i.lvl && !cfg_i.pol) |-> irq_o == !$past(sync_q[1]));

  // R6: an edge pulse lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && irq_o && !$past(cfg_i.lvl) && !cfg_i.lvl |=> !irq_o);

  // R10: a reconfiguration in edge mode does not fire
  a_r10_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !cfg_i.lvl && cfg_i != $past(cfg_i) |=> !irq_o);
endmodule

// File: rtl/extirq_norm.sv
module extirq_norm
  import extirq_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ext_pin,
  output logic [NCH-1:0]    irq_req
);
  chan_cfg_t [NCH-1:0] cfg;

  extirq_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_o     (cfg)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    extirq_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg_i (cfg[i]),
      .pin_i (ext_pin[i]),
      .irq_o (irq_req[i])
    );
  end
endmodule

// File: tb/extirq_norm_tb.sv
`timescale 1ns/1ps
module extirq_norm_tb;
  localparam int NCH = 2;
  localparam logic [31:0] CFG_LH = 32'h0001_0300;
  localparam logic [31:0] CFG_LL = 32'h0001_0200;
  localparam logic [31:0] CFG_ER = 32'h0001_0000;
  localparam logic [31:0] CFG_EF = 32'h0001_0100;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] ext_pin = '0;
  logic [NCH-1:0] irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  typedef struct {
    int    due;
    int    ch;
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  extirq_norm #(.NCH(NCH), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .irq_req(irq_req)
  );

  // monitor: pops scoreboard items as their cycle comes due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      n_cmp++;
      if (it.due != cyc || irq_req[it.ch] !== it.exp) begin
        n_bad++;
        $display("FAIL %s: irq_req[%0d] actual %b expected %b (cycle %0d due %0d)",
                 it.tag, it.ch, irq_req[it.ch], it.exp, cyc, it.due);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_at(int ch, int dly, bit v, string tag);
    exp_t it;
    it.due = cyc + dly;
    it.ch  = ch;
    it.exp = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (sb.size() > 0) step();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] e, string tag);
    step();
    bus_addr = a;
    #1;
    n_cmp++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s: read 0x%0h actual 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic set_pin(int ch, bit v);
    step();
    ext_pin[ch] = v;
  endtask

  initial begin : wdog
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : drv
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_chk(4'h4, 32'h0, "R1");
    rd_chk(4'h8, 32'h0, "R1");
    expect_at(0, 1, 1'b0, "R1");
    expect_at(1, 1, 1'b0, "R1");
    drain();

    // R2: only the three fields stick
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk(4'h4, 32'h0001_0300, "R2");
    wr(4'h4, 32'h0);
    rd_chk(4'h4, 32'h0, "R2");
    wr(4'h8, 32'h0000_0100);
    rd_chk(4'h8, 32'h0000_0100, "R2");

    // R3: global word is storage only
    wr(4'h0, 32'hA5A5_5A5A);
    rd_chk(4'h0, 32'hA5A5_5A5A, "R3");
    expect_at(0, 1, 1'b0, "R3");
    expect_at(1, 1, 1'b0, "R3");
    drain();

    // R9: unmapped and unaligned offsets
    wr(4'hC, 32'hFFFF_FFFF);
    rd_chk(4'hC, 32'h0, "R9");
    wr(4'h6, 32'hFFFF_FFFF);
    rd_chk(4'h6, 32'h0, "R9");
    rd_chk(4'h4, 32'h0, "R9");
    rd_chk(4'h8, 32'h0000_0100, "R9");
    rd_chk(4'h0, 32'hA5A5_5A5A, "R9");

    // R4: level, active high on channel 0; R11: channel 1 stays quiet
    wr(4'h4, CFG_LH);
    set_pin(0, 1'b1);
    expect_at(0, 2, 1'b0, "R4");
    expect_at(1, 2, 1'b0, "R11");
    expect_at(0, 3, 1'b1, "R4");
    expect_at(1, 3, 1'b0, "R11");
    expect_at(0, 4, 1'b1, "R4");
    drain();
    // R8: mask and unmask while the pin is active
    wr(4'h4, CFG_LH & ~32'h0001_0000);
    expect_at(0, 1, 1'b0, "R8");
    expect_at(0, 3, 1'b0, "R8");
    drain();
    wr(4'h4, CFG_LH);
    expect_at(0, 1, 1'b1, "R8");
    drain();
    set_pin(0, 1'b0);
    expect_at(0, 2, 1'b1, "R4");
    expect_at(0, 3, 1'b0, "R4");
    drain();

    // R5: level, active low on channel 1
    set_pin(1, 1'b1);
    repeat (4) step();
    wr(4'h8, CFG_LL);
    expect_at(1, 1, 1'b0, "R5");
    expect_at(1, 2, 1'b0, "R5");
    drain();
    set_pin(1, 1'b0);
    expect_at(1, 2, 1'b0, "R5");
    expect_at(1, 3, 1'b1, "R5");
    expect_at(1, 5, 1'b1, "R5");
    drain();
    set_pin(1, 1'b1);
    expect_at(1, 3, 1'b0, "R5");
    drain();

    // R6: rising edge on channel 0
    wr(4'h4, CFG_ER);
    repeat (3) step();
    set_pin(0, 1'b1);
    expect_at(0, 2, 1'b0, "R6");
    expect_at(0, 3, 1'b1, "R6");
    expect_at(0, 4, 1'b0, "R6");
    expect_at(0, 5, 1'b0, "R6");
    drain();
    set_pin(0, 1'b0);
    expect_at(0, 3, 1'b0, "R6");
    expect_at(0, 4, 1'b0, "R6");
    drain();

    // R7: falling edge on channel 1
    wr(4'h8, CFG_EF);
    repeat (3) step();
    set_pin(1, 1'b0);
    expect_at(1, 2, 1'b0, "R7");
    expect_at(1, 3, 1'b1, "R7");
    expect_at(1, 4, 1'b0, "R7");
    drain();
    set_pin(1, 1'b1);
    expect_at(1, 3, 1'b0, "R7");
    expect_at(1, 4, 1'b0, "R7");
    drain();

    // R10: switching channel 0 from rising to falling with pin low
    wr(4'h4, CFG_EF);
    expect_at(0, 1, 1'b0, "R10");
    expect_at(0, 2, 1'b0, "R10");
    expect_at(0, 3, 1'b0, "R10");
    drain();
    set_pin(0, 1'b1);
    expect_at(0, 3, 1'b0, "R10");
    drain();
    set_pin(0, 1'b0);
    expect_at(0, 3, 1'b1, "R10");
    expect_at(0, 4, 1'b0, "R10");
    drain();

    repeat (4) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule